// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block is the write side of a byte-oriented two-wire serial EEPROM slave holding 512 bytes. A separate bit-level front end turns the bus into events: start condition, stop condition, and a received byte. The block answers each received byte with an acknowledge decision one cycle later. A write transfer has three parts. First comes a command byte that names the device and carries the top address bit. Then comes a byte with the low eight address bits. Then come one or more data bytes.

Data bytes are gathered in a sixteen-slot page buffer, and each slot has its own "loaded" flag. The slot index starts at the low four bits of the start address and steps once per acknowledged byte, wrapping within the page. A stop condition after at least one data byte starts a timed programming cycle with two phases. The first phase erases every loaded byte to 0xFF. The second phase writes the buffer values into those bytes. Bytes that were never loaded keep their contents. While the cycle runs, `busy` is high and command bytes are refused, so a master can poll for completion. A combinational read port exposes the storage array to the read path.

Top module: `eep_page_writer`

## Requirements
- R1: Every received byte is answered: `ack_valid` is high in the cycle after `rx_valid`. A command byte is acknowledged only when the device is idle, its bits [7:4] equal 4'b1010 and its bit 0 (direction) is 0. Otherwise it is refused with `ack_o` low.
- R2: The start address is built from bit 1 of the command byte as address bit 8 and the following acknowledged byte as bits 7..0.
- R3: Each data byte is acknowledged. The first is stored at the start address. Each later byte goes to the next slot, where only address bits 3..0 increment, wrapping from 15 to 0 while bits 8..4 stay fixed.
- R4: When more than sixteen data bytes arrive, a slot that is written again keeps the last value sent to it.
- R5: Bytes of the page that were not loaded, and all bytes outside the page, keep their previous contents through a programming cycle.
- R6: A stop condition received after at least one data byte makes `busy` rise in the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R7: ERASE_CYCLES cycles after the stop, every loaded byte reads 0xFF. When `busy` falls, each loaded byte holds its buffered value.
- R8: While `busy` is high, command bytes are refused. Once it falls, a valid command byte is acknowledged again.
- R9: A stop condition that arrives before any data byte of the current transfer leaves `busy` low and the memory unchanged.
- R10: A start condition during data entry discards the gathered bytes without programming them.
- R11: After reset, `busy` and `ack_valid` are low and every memory byte reads 0xFF.
- R12: `rd_data` shows the byte at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| rx_valid | input | 1 | A received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| busy | output | 1 | Programming cycle in progress |
| rd_addr | input | 9 | Read-port address |
| rd_data | output | 8 | Memory byte at `rd_addr` |

## Verification
The acknowledge decision is registered, so it is due one cycle after the byte event. The bench drives each event at a falling edge, holds it across one rising edge, and reads `ack_valid`/`ack_o` at the next falling edge. `busy` is due one cycle after the stop. The erased image is due ERASE_CYCLES edges later, and the programmed image together with the fall of `busy` is due PROG_CYCLES edges after the stop. The bench counts exactly that many falling edges before each read, and it also checks that `busy` is still high one edge before its expected fall. Memory reads use the combinational port, with a sub-nanosecond settle that stays well inside the low clock phase.

// File: rtl/eep_pw_pkg.sv
// Package: shared constants and types for the page-write controller.
// Assumes a byte-level front end that delivers single-cycle event pulses.
package eep_pw_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam logic [7:0] ERASED   = 8'hFF;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_ADDR = 2'd2,
        SQ_DATA = 2'd3
    } seq_state_t;
endpackage

// File: rtl/eep_seq.sv
// Module: byte sequencer. It tracks command/address/data phases, holds the
// page address and the wrapping slot counter, and decides acknowledges.
// Assumes at most one of bus_start/bus_stop/rx_valid per cycle; start wins.
module eep_seq
    import eep_pw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 4,
    localparam int PAGE_W = ADDR_W - SLOT_W,
    localparam int HI_W   = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              busy,
    input  logic              any_valid,
    output logic              ack_valid,
    output logic              ack_o,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [SLOT_W-1:0] buf_slot,
    output logic [7:0]        buf_wdata,
    output logic [PAGE_W-1:0] page_addr,
    output logic              prog_go,
    output logic              in_data
);
    seq_state_t      state_q;
    logic [HI_W-1:0] hi_q;
    logic            cmd_ok;

    // Command byte match: device code, write direction, not busy.
    assign cmd_ok = !busy && (rx_byte[7:4] == DEV_CODE) && !rx_byte[0];

    // Phase tracking, address capture, slot stepping and ack decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            hi_q      <= '0;
            page_addr <= '0;
            buf_slot  <= '0;
            ack_valid <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            ack_valid <= rx_valid;
            ack_o     <= 1'b0;
            if (bus_start) begin
                state_q <= SQ_CMD;
            end else if (bus_stop) begin
                state_q <= SQ_IDLE;
            end else if (rx_valid) begin
                case (state_q)
                    SQ_CMD: begin
                        if (cmd_ok) begin
                            ack_o   <= 1'b1;
                            hi_q    <= rx_byte[HI_W:1];
                            state_q <= SQ_ADDR;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                    SQ_ADDR: begin
                        ack_o     <= 1'b1;
                        page_addr <= {hi_q, rx_byte[7:SLOT_W]};
                        buf_slot  <= rx_byte[SLOT_W-1:0];
                        state_q   <= SQ_DATA;
                    end
                    SQ_DATA: begin
                        ack_o    <= 1'b1;
                        buf_slot <= buf_slot + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Buffer and cycle-start strobes derived from the current phase.
    always_comb begin
        in_data   = (state_q == SQ_DATA);
        buf_clr   = bus_start && !busy;
        buf_we    = rx_valid && !bus_start && !bus_stop && in_data;
        buf_wdata = rx_byte;
        prog_go   = bus_stop && !bus_start && in_data && any_valid;
    end
endmodule

// File: rtl/eep_page_buf.sv
// Module: page buffer with one loaded flag per slot. A clear drops all flags;
// a write stores the byte and sets that slot's flag (last write wins).
module eep_page_buf #(
    parameter int SLOT_W = 4,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [7:0]         wdata,
    output logic [SLOTS*8-1:0] data_flat,
    output logic [SLOTS-1:0]   loaded,
    output logic               any_loaded
);
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            // Per-slot storage and loaded flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_flat[g*8 +: 8] <= '0;
                    loaded[g]           <= 1'b0;
                end else if (clr) begin
                    loaded[g] <= 1'b0;
                end else if (we && (slot == SLOT_W'(g))) begin
                    data_flat[g*8 +: 8] <= wdata;
                    loaded[g]           <= 1'b1;
                end
            end
        end
    endgenerate

    // Summary flag used to qualify the cycle start.
    assign any_loaded = |loaded;
endmodule

// File: rtl/eep_prog_ctl.sv
// Module: programming-cycle timer. It runs PROG_CYCLES cycles after a start
// pulse, strobes the erase step at ERASE_CYCLES and the write step at the end.
module eep_prog_ctl #(
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 20,
    localparam int TMR_W = $clog2(PROG_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic erase_stb,
    output logic write_stb
);
    logic [TMR_W-1:0] tmr_q;

    // Busy flag and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tmr_q <= '0;
        end else if (busy) begin
            if (tmr_q == TMR_W'(PROG_CYCLES - 1)) begin
                busy  <= 1'b0;
                tmr_q <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end else if (go) begin
            busy  <= 1'b1;
            tmr_q <= '0;
        end
    end

    // Step strobes, each one cycle wide.
    assign erase_stb = busy && (tmr_q == TMR_W'(ERASE_CYCLES - 1));
    assign write_stb = busy && (tmr_q == TMR_W'(PROG_CYCLES - 1));
endmodule

// File: rtl/eep_mem_array.sv
// Module: register-array storage. Erase and write steps touch only loaded
// slots of the selected page; reset fills the array with the erased value.
module eep_mem_array
    import eep_pw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int SLOTS  = 1 << SLOT_W,
    localparam int PAGE_W = ADDR_W - SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               erase_stb,
    input  logic               write_stb,
    input  logic [PAGE_W-1:0]  page,
    input  logic [SLOTS-1:0]   loaded,
    input  logic [SLOTS*8-1:0] data_flat,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data
);
    logic [7:0] mem [DEPTH];

    // Selective erase-then-write of the page's loaded bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (loaded[s]) begin
                    if (erase_stb)      mem[{page, SLOT_W'(s)}] <= ERASED;
                    else if (write_stb) mem[{page, SLOT_W'(s)}] <= data_flat[s*8 +: 8];
                end
            end
        end
    end

    // Combinational read port for the read path.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_page_writer.sv
// Module: top of the page-write controller. It connects the sequencer,
// the page buffer, the cycle timer and the storage array.
// Assumes PROG_CYCLES at the clock rate is at most 8 ms and that
// ERASE_CYCLES lies between 1 and PROG_CYCLES-1.
module eep_page_writer #(
    parameter int MEM_BYTES    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 20,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam int SLOT_W = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              ack_valid,
    output logic              ack_o,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic                  buf_clr, buf_we, prog_go, in_data, any_valid;
    logic [SLOT_W-1:0]     buf_slot;
    logic [7:0]            buf_wdata;
    logic [PAGE_W-1:0]     page_addr;
    logic [PAGE_BYTES*8-1:0] buf_flat;
    logic [PAGE_BYTES-1:0] buf_loaded;
    logic                  erase_stb, write_stb;

    eep_seq #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy), .any_valid(any_valid),
        .ack_valid(ack_valid), .ack_o(ack_o), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_slot(buf_slot), .buf_wdata(buf_wdata), .page_addr(page_addr),
        .prog_go(prog_go), .in_data(in_data)
    );

    eep_page_buf #(.SLOT_W(SLOT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .slot(buf_slot),
        .wdata(buf_wdata), .data_flat(buf_flat), .loaded(buf_loaded),
        .any_loaded(any_valid)
    );

    eep_prog_ctl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .busy(busy),
        .erase_stb(erase_stb), .write_stb(write_stb)
    );

    eep_mem_array #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .erase_stb(erase_stb), .write_stb(write_stb),
        .page(page_addr), .loaded(buf_loaded), .data_flat(buf_flat),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/eep_page_writer_chk.sv
// Module: property checker bound to the top; it observes ports and the
// signals between the sequencer, buffer and timer.
module eep_page_writer_chk #(
    parameter int SLOT_W      = 4,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 40,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              bus_stop,
    input logic              ack_valid,
    input logic              ack_o,
    input logic              busy,
    input logic              prog_go,
    input logic              in_data,
    input logic              buf_we,
    input logic [SLOT_W-1:0] buf_slot,
    input logic [PAGE_W-1:0] page_addr
);
    logic [CNT_W-1:0] bcnt;

    // Counts cycles spent busy.
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else        bcnt <= busy ? bcnt + 1'b1 : '0;
    end

    a_r1_answer_every_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ack_valid);
    a_r8_refuse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && busy) |=> !ack_o);
    a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy);
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == CNT_W'(PROG_CYCLES)));
    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < CNT_W'(PROG_CYCLES)));
    a_r3_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (buf_slot == SLOT_W'($past(buf_slot) + 1'b1)));
    a_r9_no_cycle_without_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !in_data && !busy) |=> !busy);
    a_r5_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_addr));
endmodule

bind eep_page_writer eep_page_writer_chk #(
    .SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_stop(bus_stop),
    .ack_valid(ack_valid), .ack_o(ack_o), .busy(busy), .prog_go(prog_go),
    .in_data(in_data), .buf_we(buf_we), .buf_slot(buf_slot), .page_addr(page_addr)
);

// File: tb/eep_page_writer_bench.sv
module eep_page_writer_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLK_PERIOD = 10;
    localparam int PROG  = 40;
    localparam int ERASE = 20;
    localparam int WATCHDOG = 20000;

    // Vector fields: [39:32] A8, [31:24] low address, [23:16] byte count,
    // [15:8] seed (byte k = seed + 7k), [7:0] expected byte at start address.
    localparam int NVEC = 5;
    localparam logic [39:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 8'd4,  8'h10, 8'h10},
        {8'h01, 8'h35, 8'd16, 8'h40, 8'h40},
        {8'h00, 8'h7E, 8'd3,  8'h80, 8'h80},
        {8'h01, 8'hF0, 8'd1,  8'hC3, 8'hC3},
        {8'h00, 8'h02, 8'd20, 8'h20, 8'h90}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       ack_valid, ack_o, busy;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_page_writer #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u_eep_page_writer (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ack_valid(ack_valid),
        .ack_o(ack_o), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [8:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic av, output logic a);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        av = ack_valid; a = ack_o;
    endtask

    task automatic run_page(input logic a8, input logic [7:0] lo, input int n,
                            input logic [7:0] seed, input logic [7:0] exp_first);
        logic av, a;
        logic [7:0] d, got;
        logic [7:0] pbuf [16];
        bit touched [16];
        logic [8:0] base;
        int slot;
        base = {a8, lo[7:4], 4'h0};
        for (int i = 0; i < 16; i++) touched[i] = 1'b0;
        pulse_start();
        send_byte({4'b1010, 2'b00, a8, 1'b0}, av, a);
        check(av && a, "R1 command ack", {av, a}, 2'b11);
        send_byte(lo, av, a);
        check(av && a, "R2 address ack", {av, a}, 2'b11);
        for (int k = 0; k < n; k++) begin
            d = 8'(seed + 8'(k * 7));
            send_byte(d, av, a);
            check(av && a, "R3 data ack", {av, a}, 2'b11);
            slot = (int'(lo[3:0]) + k) % 16;
            pbuf[slot] = d;
            touched[slot] = 1'b1;
        end
        pulse_stop();
        check(busy === 1'b1, "R6 busy after stop", busy, 1);
        repeat (ERASE) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            peek(base + 9'(i), got);
            if (touched[i]) check(got === 8'hFF, "R7 erased", got, 8'hFF);
            else            check(got === model[base + 9'(i)], "R5 untouched mid-cycle",
                                  got, model[base + 9'(i)]);
        end
        repeat (PROG - ERASE - 1) @(negedge clk);
        check(busy === 1'b1, "R6 busy held", busy, 1);
        @(negedge clk);
        check(busy === 1'b0, "R6 busy ends", busy, 0);
        for (int i = 0; i < 16; i++)
            if (touched[i]) model[base + 9'(i)] = pbuf[i];
        for (int i = 0; i < 16; i++) begin
            peek(base + 9'(i), got);
            check(got === model[base + 9'(i)], "R3/R5/R7 page content",
                  got, model[base + 9'(i)]);
        end
        peek(base + 9'd16, got);
        check(got === model[base + 9'd16], "R5 next page", got, model[base + 9'd16]);
        peek({a8, lo}, got);
        check(got === exp_first, "R2/R4 start byte", got, exp_first);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic av, a;
        logic [7:0] got;
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 and R12: reset state
        check(busy === 1'b0, "R11 busy reset", busy, 0);
        check(ack_valid === 1'b0, "R11 ack_valid reset", ack_valid, 0);
        peek(9'h000, got);
        check(got === 8'hFF, "R11 R12 memory reset low", got, 8'hFF);
        peek(9'h1FF, got);
        check(got === 8'hFF, "R11 R12 memory reset high", got, 8'hFF);

        // Table walk
        for (int v = 0; v < NVEC; v++)
            run_page(VECS[v][32], VECS[v][31:24], int'(VECS[v][23:16]),
                     VECS[v][15:8], VECS[v][7:0]);

        // R1: wrong device code and read direction are refused
        pulse_start();
        send_byte(8'hB0, av, a);
        check(av === 1'b1 && a === 1'b0, "R1 wrong code refused", {av, a}, 2'b10);
        pulse_start();
        send_byte(8'hA1, av, a);
        check(av === 1'b1 && a === 1'b0, "R1 read direction refused", {av, a}, 2'b10);

        // R8: polling while busy
        pulse_start();
        send_byte(8'hA2, av, a);
        send_byte(8'hA7, av, a);
        send_byte(8'h5A, av, a);
        pulse_stop();
        pulse_start();
        send_byte(8'hA2, av, a);
        check(av === 1'b1 && a === 1'b0, "R8 refused while busy", {av, a}, 2'b10);
        for (int i = 0; i < PROG + 5 && busy; i++) @(negedge clk);
        check(busy === 1'b0, "R8 cycle completes", busy, 0);
        model[9'h1A7] = 8'h5A;
        peek(9'h1A7, got);
        check(got === 8'h5A, "R8 polled write stored", got, 8'h5A);
        pulse_start();
        send_byte(8'hA0, av, a);
        check(av && a, "R8 acked after cycle", {av, a}, 2'b11);

        // R9: stop after the command only, and after the address only
        pulse_stop();
        check(busy === 1'b0, "R9 stop after command", busy, 0);
        pulse_start();
        send_byte(8'hA0, av, a);
        send_byte(8'h40, av, a);
        pulse_stop();
        check(busy === 1'b0, "R9 stop after address", busy, 0);
        peek(9'h040, got);
        check(got === model[9'h040], "R9 memory unchanged", got, model[9'h040]);

        // R10: restart during data entry drops the gathered bytes
        pulse_start();
        send_byte(8'hA0, av, a);
        send_byte(8'h60, av, a);
        send_byte(8'h11, av, a);
        send_byte(8'h22, av, a);
        pulse_start();
        pulse_stop();
        check(busy === 1'b0, "R10 no cycle after restart", busy, 0);
        repeat (PROG + 2) @(negedge clk);
        peek(9'h060, got);
        check(got === model[9'h060], "R10 byte 0x60 kept", got, model[9'h060]);
        peek(9'h061, got);
        check(got === model[9'h061], "R10 byte 0x61 kept", got, model[9'h061]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule